// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is the serial configuration port of a clock-distribution chip. It holds seven configuration bytes and serves them to an SMBus host through block write and block read transfers. Each transfer always starts at byte 0. Software uses it to set the divider, the PLL mode, the PLL bandwidth, the output drive modes for power-down and for stopped outputs, a per-output enable mask and a per-output stoppable mask. The block decodes these settings onto plain control outputs for the rest of the chip.

The serial lines are modelled as open-drain. The block samples SCL and SDA through a two-stage synchroniser. It can only pull SDA low, and it does so through `sdaDriveLow`. On the board, the line level is the wired-AND of all devices on the bus.

A writable byte-count register sets how many bytes a block read returns. Two identification bytes are constant. Writes that target them are acknowledged and then dropped.

Top module: `cfgSmbSlave`

## Requirements
- R1: The block acknowledges the address byte 0xDC (write) and 0xDD (read). For any other address byte it leaves SDA released during the acknowledge slot and stays silent until the next START.
- R2: Byte 0 resets to 0x07 and drives the following outputs:
  - bit 0 drives `divBypass` (1 = pass-through, 0 = divide by two).
  - bit 1 drives `pllZeroDelay` (1 = zero-delay PLL, 0 = fan-out buffer).
  - bit 2 drives `pllBwLow` (1 = low bandwidth).
  - bit 6 drives `stopHiZ` (1 = high impedance).
  - bit 7 drives `pdHiZ` (1 = high impedance).
- R3: Byte 1 resets to 0xFF and drives `outEnable` bit for bit (1 = enabled). Byte 2 resets to 0x00 and drives `outStoppable` bit for bit (1 = stoppable). Byte 3 resets to 0x00.
- R4: A block write is the address byte, then a count byte, then data bytes. Data byte k goes to index k only while k < count and k < 7. Every byte of the transfer, including the excess ones, is acknowledged.
- R5: Byte 4 reads as {revision[3:0], 4'b0001} and byte 5 reads as 0x08. Writes to either byte are acknowledged and have no effect.
- R6: Byte 6 is the byte count and resets to 0x05. A block read first sends the value of byte 6, then sends bytes from index 0 upward.
- R7: During a block read, data byte k for k ≥ byte-count or k ≥ 7 is sent as 0xFF, which leaves SDA released.
- R8: When the master NACKs a read byte, the transfer ends and SDA stays released until the next START.
- R9: A STOP in the middle of a byte discards the partial byte, leaves all registers unchanged and returns the block to idle.
- R10: A START in the middle of a byte abandons the transfer and makes the next byte an address byte.
- R11: The block changes its SDA drive only while SCL is low, and it releases SDA when idle.
- R12: A register changes only when a complete, in-window data byte is received, and each such byte causes exactly one register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (wired-AND of all drivers) |
| sdaDriveLow | output | 1 | 1 = block pulls SDA low |
| pdHiZ | output | 1 | Power-down drive mode, 1 = Hi-Z |
| stopHiZ | output | 1 | Stopped-output drive mode, 1 = Hi-Z |
| pllBwLow | output | 1 | 1 = low PLL bandwidth |
| pllZeroDelay | output | 1 | 1 = zero-delay PLL, 0 = fan-out buffer |
| divBypass | output | 1 | 1 = pass-through, 0 = divide by two |
| outEnable | output | 8 | Per-output enable mask |
| outStoppable | output | 8 | Per-output stoppable mask |

## Verification
The bus-condition detector and the bit shifter both react to the same synchronised SDA and SCL samples. In any cycle where SDA moves while SCL is high, the event must be treated as a START or STOP and not as a data bit, even when a byte is only partly shifted in. The bench provokes this by issuing a STOP after three data bits and a repeated START after four. It judges the outcome at the ports: the half-built byte must leave every register unchanged on readback, and the address byte that follows the repeated START must be acknowledged and answered with the current count.

// File: rtl/cfgSmbPkg.sv
package cfgSmbPkg;
  localparam int NUM_BYTES = 7;
  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam int ID_BYTE = 4;
  localparam int DEV_BYTE = 5;
  localparam int CNT_BYTE = 6;
  localparam logic [3:0] VENDOR_ID = 4'b0001;
  localparam logic [7:0] DEVICE_ID = 8'h08;
  localparam logic [6:0] DEV_ADDR = 7'h6E;

  typedef struct packed {
    logic wrEn;
    logic [IDX_W-1:0] idx;
    logic [7:0] data;
  } regStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK_WAIT, ST_RXACK, ST_TX, ST_TXACK, ST_TXACK_WAIT
  } busState_t;
endpackage

// File: rtl/cfgSmbSync.sv
module cfgSmbSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclLevel = sclPipe[SYNC_STAGES-1];
  assign sdaLevel = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign startDet = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopDet  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;
endmodule

// File: rtl/cfgSmbCtrl.sv
module cfgSmbCtrl
  import cfgSmbPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclLevel,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             sdaLevel,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic [7:0]       rdByte,
  input  logic [7:0]       byteCount,
  output logic [IDX_W-1:0] rdIdx,
  output regStrobe_t       strobe,
  output logic             sdaDriveLow
);
  localparam logic [7:0] NB8 = 8'(NUM_BYTES);

  busState_t state;
  logic [7:0] shiftReg, xferIdx, limit;
  logic [2:0] bitCnt;
  logic isAddr, isRead, haveCount, ackFlag;
  logic [7:0] rxByte, txNext, idxNext;
  logic inWindow;

  always_comb begin
    rxByte   = {shiftReg[6:0], sdaLevel};
    inWindow = (xferIdx < limit) && (xferIdx < NB8);
    txNext   = inWindow ? rdByte : 8'hFF;
    idxNext  = (xferIdx == 8'hFF) ? xferIdx : xferIdx + 8'd1;
  end

  assign rdIdx = xferIdx[IDX_W-1:0];
  assign sdaDriveLow = ((state == ST_RXACK) && ackFlag) ||
                       ((state == ST_TX) && !shiftReg[7]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      shiftReg  <= 8'hFF;
      xferIdx   <= '0;
      limit     <= '0;
      bitCnt    <= '0;
      isAddr    <= 1'b0;
      isRead    <= 1'b0;
      haveCount <= 1'b0;
      ackFlag   <= 1'b0;
      strobe    <= '0;
    end else begin
      strobe <= '0;
      if (startDet) begin
        state     <= ST_RX;
        bitCnt    <= '0;
        isAddr    <= 1'b1;
        isRead    <= 1'b0;
        haveCount <= 1'b0;
        ackFlag   <= 1'b0;
        xferIdx   <= '0;
        shiftReg  <= 8'hFF;
      end else if (stopDet) begin
        state    <= ST_IDLE;
        shiftReg <= 8'hFF;
      end else begin
        unique case (state)
          ST_RX: if (sclRise) begin
            shiftReg <= rxByte;
            bitCnt   <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              state <= ST_RXACK_WAIT;
              if (isAddr) begin
                ackFlag <= (rxByte[7:1] == DEV_ADDR);
                isRead  <= rxByte[0];
                isAddr  <= 1'b0;
              end else if (!haveCount) begin
                limit     <= rxByte;
                haveCount <= 1'b1;
                ackFlag   <= 1'b1;
              end else begin
                ackFlag <= 1'b1;
                if (inWindow) begin
                  strobe.wrEn <= 1'b1;
                  strobe.idx  <= xferIdx[IDX_W-1:0];
                  strobe.data <= rxByte;
                end
                xferIdx <= idxNext;
              end
            end
          end
          ST_RXACK_WAIT: if (sclFall) state <= ST_RXACK;
          ST_RXACK: if (sclFall) begin
            bitCnt <= '0;
            if (!ackFlag) begin
              state <= ST_IDLE;
            end else if (isRead) begin
              shiftReg <= byteCount;
              limit    <= byteCount;
              xferIdx  <= '0;
              state    <= ST_TX;
            end else begin
              state <= ST_RX;
            end
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == 3'd7) begin
              state    <= ST_TXACK;
              shiftReg <= 8'hFF;
            end else begin
              shiftReg <= {shiftReg[6:0], 1'b1};
              bitCnt   <= bitCnt + 3'd1;
            end
          end
          ST_TXACK: if (sclRise) state <= sdaLevel ? ST_IDLE : ST_TXACK_WAIT;
          ST_TXACK_WAIT: if (sclFall) begin
            shiftReg <= txNext;
            xferIdx  <= idxNext;
            bitCnt   <= '0;
            state    <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (int'(strobe.idx) < NUM_BYTES)); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow); // R9
  AST_START_REARM: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_RX && bitCnt == 3'd0 && isAddr)); // R10
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> !strobe.wrEn); // R12
  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclLevel); // R11
endmodule

// File: rtl/cfgSmbRegs.sv
module cfgSmbRegs
  import cfgSmbPkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdByte,
  output logic [7:0]       byteCount,
  output logic             pdHiZ,
  output logic             stopHiZ,
  output logic             pllBwLow,
  output logic             pllZeroDelay,
  output logic             divBypass,
  output logic [7:0]       outEnable,
  output logic [7:0]       outStoppable
);
  function automatic logic [7:0] resetVal(int i);
    case (i)
      0:        return 8'h07;
      1:        return 8'hFF;
      ID_BYTE:  return {REV_ID, VENDOR_ID};
      DEV_BYTE: return DEVICE_ID;
      CNT_BYTE: return 8'h05;
      default:  return 8'h00;
    endcase
  endfunction

  logic [7:0] bytes [NUM_BYTES];
  logic [NUM_BYTES*8-1:0] flat;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gByte
    if (g == ID_BYTE || g == DEV_BYTE) begin : gRo
      assign bytes[g] = resetVal(g);
    end else begin : gRw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bytes[g] <= resetVal(g);
        else if (strobe.wrEn && strobe.idx == IDX_W'(g)) bytes[g] <= strobe.data;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BYTES; i++) flat[i*8 +: 8] = bytes[i];
    rdByte = (int'(rdIdx) < NUM_BYTES) ? bytes[rdIdx] : 8'hFF;
  end

  assign byteCount    = bytes[CNT_BYTE];
  assign divBypass    = bytes[0][0];
  assign pllZeroDelay = bytes[0][1];
  assign pllBwLow     = bytes[0][2];
  assign stopHiZ      = bytes[0][6];
  assign pdHiZ        = bytes[0][7];
  assign outEnable    = bytes[1];
  assign outStoppable = bytes[2];

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(flat)); // R12
  AST_RO_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && (int'(strobe.idx) == ID_BYTE || int'(strobe.idx) == DEV_BYTE))
    |=> $stable(flat)); // R5
endmodule

// File: rtl/cfgSmbSlave.sv
module cfgSmbSlave
  import cfgSmbPkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  output logic       pdHiZ,
  output logic       stopHiZ,
  output logic       pllBwLow,
  output logic       pllZeroDelay,
  output logic       divBypass,
  output logic [7:0] outEnable,
  output logic [7:0] outStoppable
);
  logic sclLevel, sdaLevel, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rdByte, byteCount;
  logic [IDX_W-1:0] rdIdx;
  regStrobe_t strobe;

  cfgSmbSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet));

  cfgSmbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sclRise(sclRise),
    .sclFall(sclFall), .sdaLevel(sdaLevel), .startDet(startDet),
    .stopDet(stopDet), .rdByte(rdByte), .byteCount(byteCount),
    .rdIdx(rdIdx), .strobe(strobe), .sdaDriveLow(sdaDriveLow));

  cfgSmbRegs #(.REV_ID(REV_ID)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(rdIdx),
    .rdByte(rdByte), .byteCount(byteCount), .pdHiZ(pdHiZ),
    .stopHiZ(stopHiZ), .pllBwLow(pllBwLow), .pllZeroDelay(pllZeroDelay),
    .divBypass(divBypass), .outEnable(outEnable), .outStoppable(outStoppable));
endmodule

// File: tb/cfgSmbSlave_test.sv
`timescale 1ns/1ps
module cfgSmbSlave_test;
  localparam int Q = 6;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine, sdaDriveLow, pdHiZ, stopHiZ, pllBwLow, pllZeroDelay, divBypass;
  logic [7:0] outEnable, outStoppable;
  assign sdaLine = sdaM & ~sdaDriveLow;

  cfgSmbSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .pdHiZ(pdHiZ), .stopHiZ(stopHiZ),
    .pllBwLow(pllBwLow), .pllZeroDelay(pllZeroDelay), .divBypass(divBypass),
    .outEnable(outEnable), .outStoppable(outStoppable));

  int checks = 0, fails = 0, glitches = 0;
  bit done = 0;
  logic [7:0] model [7];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1; tick(Q); sclM = 1; tick(Q); sdaM = 0; tick(Q); sclM = 0; tick(Q);
  endtask
  task automatic busStop();
    sclM = 0; sdaM = 0; tick(Q); sclM = 1; tick(Q); sdaM = 1; tick(Q);
  endtask
  task automatic sendBit(logic b);
    sdaM = b; tick(Q); sclM = 1; tick(Q); sclM = 0; tick(Q);
  endtask
  task automatic recvBit(output logic b);
    logic s1;
    sdaM = 1; tick(Q); sclM = 1; tick(Q/2); s1 = sdaLine; tick(Q/2);
    if (sdaLine !== s1) glitches++;
    b = s1; sclM = 0; tick(Q);
  endtask
  task automatic sendByte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(ack);
  endtask
  task automatic recvByte(output logic [7:0] v, input logic masterNack);
    for (int i = 7; i >= 0; i--) recvBit(v[i]);
    sendBit(masterNack);
  endtask

  function automatic logic [7:0] expByte(int k);
    return (k < int'(model[6]) && k < 7) ? model[k] : 8'hFF;
  endfunction

  task automatic blockWrite(logic [7:0] cnt, int n, output logic allAck);
    logic a;
    allAck = 1;
    busStart();
    sendByte(8'hDC, a); if (a) allAck = 0;
    sendByte(cnt, a);   if (a) allAck = 0;
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], a); if (a) allAck = 0;
      if (i < int'(cnt) && i < 7 && i != 4 && i != 5) model[i] = wbuf[i];
    end
    busStop();
  endtask

  task automatic blockRead(int n, output logic [7:0] cnt, output logic addrAck,
                           output logic relBit);
    logic a;
    busStart();
    sendByte(8'hDD, a); addrAck = ~a;
    recvByte(cnt, n == 0);
    for (int i = 0; i < n; i++) recvByte(rbuf[i], i == n - 1);
    recvBit(relBit);
    busStop();
  endtask

  task automatic readCompare(string tag, int n);
    logic [7:0] cnt; logic aa, rel;
    blockRead(n, cnt, aa, rel);
    chk({tag, " addr ack R1"}, aa, 1);
    chk({tag, " count R6"}, cnt, model[6]);
    for (int i = 0; i < n; i++) chk($sformatf("%s byte%0d R6/R7", tag, i), rbuf[i], expByte(i));
  endtask

  task automatic chkOutputs(string tag);
    chk({tag, " byte0 fields R2"}, {pdHiZ, stopHiZ, pllBwLow, pllZeroDelay, divBypass},
        {model[0][7], model[0][6], model[0][2], model[0][1], model[0][0]});
    chk({tag, " enables R3"}, outEnable, model[1]);
    chk({tag, " stoppable R3"}, outStoppable, model[2]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic a, ok, aa, rel;
    logic [7:0] cnt;
    void'($urandom(32'h5EED));
    model[0] = 8'h07; model[1] = 8'hFF; model[2] = 8'h00; model[3] = 8'h00;
    model[4] = 8'h21; model[5] = 8'h08; model[6] = 8'h05;
    tick(5); rstN = 1; tick(5);

    // R2 R3 R11: reset state
    chkOutputs("reset");
    chk("reset sda released R11", sdaDriveLow, 0);
    // R6 R7: default read, count 5, bytes past count are 0xFF
    readCompare("default read", 7);

    // R1: foreign address not acknowledged
    busStart(); sendByte(8'hA0, a); busStop();
    chk("foreign addr nack R1", a, 1);

    // R4: plain block write
    for (int i = 0; i < 3; i++) wbuf[i] = 8'($urandom);
    blockWrite(8'd3, 3, ok);
    chk("write acks R4", ok, 1);
    chkOutputs("write3");
    readCompare("after write3", 5);

    // R4: excess data bytes acked and dropped
    for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
    blockWrite(8'd2, 4, ok);
    chk("excess acks R4", ok, 1);
    readCompare("after excess R4", 5);

    // R5: read-only bytes ignore writes
    for (int i = 0; i < 6; i++) wbuf[i] = 8'($urandom) | 8'h40;
    blockWrite(8'd6, 6, ok);
    chk("ro acks R5", ok, 1);
    readCompare("after ro R5", 5);
    chkOutputs("ro");

    // R6 R7: shrink count to 3, then grow to 7
    for (int i = 0; i < 6; i++) wbuf[i] = model[i];
    wbuf[6] = 8'd3;
    blockWrite(8'd7, 7, ok);
    chk("count3 model R6", model[6], 3);
    readCompare("count3", 6);
    wbuf[6] = 8'd7;
    blockWrite(8'd7, 7, ok);
    readCompare("count7", 8);

    // R8: NACK after first data byte ends the read
    blockRead(1, cnt, aa, rel);
    chk("nack release R8", rel, 1);
    chk("nack byte0 R8", rbuf[0], model[0]);
    readCompare("after nack R8", 7);

    // R9: STOP after three data bits
    busStart(); sendByte(8'hDC, a); sendByte(8'h01, a);
    sendBit(~model[0][7]); sendBit(~model[0][6]); sendBit(~model[0][5]);
    busStop();
    readCompare("mid-byte stop R9", 7);
    chkOutputs("mid-byte stop R9");

    // R10: repeated START after four data bits
    busStart(); sendByte(8'hDC, a); sendByte(8'h01, a);
    for (int i = 0; i < 4; i++) sendBit(~model[0][7-i]);
    busStart(); sendByte(8'hDD, a);
    chk("restart addr ack R10", a, 0);
    recvByte(cnt, 1'b1);
    chk("restart count R10", cnt, model[6]);
    busStop();
    chkOutputs("restart R10");

    // R4 R12: random block writes mixed with readback
    for (int t = 0; t < 8; t++) begin
      int n = 1 + int'($urandom % 4);
      logic [7:0] c = 8'($urandom % 5);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      blockWrite(c, n, ok);
      chk("random acks R4", ok, 1);
      readCompare("random R12", 7);
      chkOutputs("random R12");
    end

    chk("sda steady while scl high R11", glitches, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule